// File: doc/BRIEF.md
# Stack Machine Instruction Sequencer

This block sits at the front of a two-stack processor. Each cycle it decodes the 32-bit instruction word being executed and picks the word address of the next fetch. That address can be the incremented program counter, an absolute target carried in the instruction, the top of the return stack, or a fixed vector. It also turns the instruction into the strobes the datapath needs: register selects, stack push and pop controls, the ALU control field or memory offset, and the choice of address source. The fetch of the following instruction overlaps the execution of the current one, so ordinary instructions take one cycle. Loads and stores take two cycles: the first computes the address, the second uses the bus for the data transfer.

The sequencer also arbitrates three outside events. After reset it fetches from the reset vector. When an interrupt is requested and enabled, it takes the interrupt at an instruction boundary. When a bus master asks for direct memory access, it releases the bus. The datapath can write the interrupt-enable and cache-enable status bits through a status write port.

Top module: `stack_seq`

## Requirements
- R1: In the first cycle after reset is released, the block fetches word 0 (addrSel = 1, memRead = 1). In that cycle intEn and cacheEn read 0, busOe is 1 and dmaAck is 0.
- R2: The opcode is instr[31:29]. Opcode 000 is a call: it fetches instr[28:0], pushes the return stack (rsPush = 1, pushRet = 1) and presents program counter + 1 on retAddr.
- R3: Opcode 001 branches to instr[28:0]. Opcode 010 branches to instr[28:0] only when flag is 0; when flag is 1 it fetches program counter + 1. Neither changes a stack.
- R4: For opcodes 011 to 111 the field layout is as follows. instr[27:24] drives r1Sel and instr[23:20] drives r2Sel. instr[19:18] controls the parameter stack and instr[17:16] the return stack, with code 01 meaning push, 10 meaning pop, and 00 or 11 meaning no change. instr[15:0] drives aluField. Opcode 011, the microinstruction, sets r2Write with immMode = 0.
- R5: For opcodes 011 to 111, the next bit instr[28] selects the next fetch address: rsTop when the bit is 1, program counter + 1 when it is 0.
- R6: Opcode 110 writes R1 + offset into R2 (immMode = 1, r2Write = 1). Opcode 111 writes R1 + offset shifted left by 16 (immMode = 2, r2Write = 1).
- R7: Load (100) and store (101) take two cycles. In the first cycle immMode = 1 and the next instruction is fetched. In the second cycle addrSel = 2 (data) and r2Sel is the instruction's R2 field, with no stack activity and no fetch. Load sets memRead and r2Write; store sets memWrite only.
- R8: No stack is pushed and popped in the same cycle.
- R9: When irqReq is high with intEn set in an execute cycle, the current instruction is discarded: no r2Write and no stack-field action. In that cycle irqAck is 1, word 1 is fetched, and the return stack is pushed with the discarded instruction's address on retAddr. intEn reads 0 from the next cycle on.
- R10: An interrupt is never accepted while intEn is 0, nor in the data cycle of a load or store.
- R11: A dmaReq seen in an execute or boot cycle turns that cycle idle: addrSel = 0, no fetch, nothing executed. From the next cycle, dmaAck = 1 and busOe = 0, including the cycle in which dmaReq is first seen low; execution then resumes. A dmaReq raised in a data cycle waits until that cycle completes.
- R12: When DMA and an interrupt are both requested in the same execute cycle, DMA wins. The interrupt is then accepted in the first execute cycle after the bus is returned.
- R13: statusWr loads intEn from statusIe and cacheEn from statusCe at the clock edge. Accepting an interrupt clears intEn and overrides any status write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| instr | input | 32 | Instruction word being executed, held by the instruction register |
| flag | input | 1 | Condition flag |
| rsTop | input | 29 | Top of the return stack as a word address |
| irqReq | input | 1 | Interrupt request |
| dmaReq | input | 1 | Bus request from a DMA master |
| statusWr | input | 1 | Status bit write strobe |
| statusIe | input | 1 | Interrupt-enable value to write |
| statusCe | input | 1 | Cache-enable value to write |
| fetchAddr | output | 29 | Next instruction word address |
| addrSel | output | 2 | Address source: 0 idle, 1 fetch, 2 data (ALU result) |
| memRead | output | 1 | Memory read (fetch or load data) |
| memWrite | output | 1 | Memory write (store data) |
| busOe | output | 1 | Bus output enable; 0 floats address, data and read lines |
| dmaAck | output | 1 | DMA grant |
| irqAck | output | 1 | Interrupt accepted this cycle |
| r1Sel | output | 4 | Source register select |
| r2Sel | output | 4 | Destination (or store source) register select |
| r2Write | output | 1 | Write the result into R2 |
| psPush | output | 1 | Push parameter stack |
| psPop | output | 1 | Pop parameter stack |
| rsPush | output | 1 | Push return stack |
| rsPop | output | 1 | Pop return stack |
| pushRet | output | 1 | Return stack push data comes from retAddr |
| retAddr | output | 29 | Return address for call or interrupt |
| aluField | output | 16 | ALU control field or unsigned offset |
| immMode | output | 2 | 0 ALU field, 1 R1 + offset, 2 R1 + offset shifted left by 16 |
| intEn | output | 1 | Interrupt enable status bit |
| cacheEn | output | 1 | Stack cache enable status bit |

## Verification
Two pairs of events can collide in one cycle. An interrupt can meet the data cycle of a load, and an interrupt can meet a DMA request. The bench raises irqReq exactly in a load's second cycle and checks that irqAck stays low there and rises in the next execute cycle. It also raises dmaReq and irqReq together on one edge and checks that the bus floats first. The interrupt, still pending, must then be accepted with the return address of the instruction that was held during the DMA stall. A store that meets a DMA request in its data cycle is checked to finish its write before the bus is released.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  typedef enum logic [2:0] {
    OP_CALL  = 3'd0,
    OP_BR    = 3'd1,
    OP_CBR   = 3'd2,
    OP_MICRO = 3'd3,
    OP_LOAD  = 3'd4,
    OP_STORE = 3'd5,
    OP_LAL   = 3'd6,
    OP_LAH   = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    ST_BOOT, ST_EXEC, ST_DATA, ST_DMA
  } seqState_e;

  typedef enum logic [2:0] {
    NXT_INC, NXT_TGT, NXT_RET, NXT_RESET, NXT_IRQ
  } nextSrc_e;

  typedef enum logic [1:0] {
    ADDR_NONE  = 2'd0,
    ADDR_FETCH = 2'd1,
    ADDR_DATA  = 2'd2
  } addrSel_e;

  typedef enum logic [1:0] {
    IMM_ALU = 2'd0,
    IMM_LO  = 2'd1,
    IMM_HI  = 2'd2
  } immMode_e;

  localparam logic [1:0] STK_PUSH = 2'b01;
  localparam logic [1:0] STK_POP  = 2'b10;

  // strobes from control to the address datapath
  typedef struct packed {
    nextSrc_e nextSrc;
    logic     fetch;
    logic     retCur;
  } seqStrobe_t;

endpackage

// File: rtl/stack_seq_dpath.sv
module stack_seq_dpath
  import stack_seq_pkg::*;
#(
  parameter int ADDR_W    = 29,
  parameter int RESET_VEC = 0,
  parameter int IRQ_VEC   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] rsTop,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] retAddr
);

  localparam logic [ADDR_W-1:0] RST_ADDR = ADDR_W'(RESET_VEC);
  localparam logic [ADDR_W-1:0] IRQ_ADDR = ADDR_W'(IRQ_VEC);

  logic [ADDR_W-1:0] pcReg;
  logic [ADDR_W-1:0] pcInc;

  assign pcInc = pcReg + ADDR_W'(1);

  always_comb begin
    unique case (strobe.nextSrc)
      NXT_TGT:   fetchAddr = target;
      NXT_RET:   fetchAddr = rsTop;
      NXT_RESET: fetchAddr = RST_ADDR;
      NXT_IRQ:   fetchAddr = IRQ_ADDR;
      default:   fetchAddr = pcInc;
    endcase
  end

  // interrupt resumes at the discarded word, a call after itself
  assign retAddr = strobe.retCur ? pcReg : pcInc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pcReg <= RST_ADDR;
    else if (strobe.fetch) pcReg <= fetchAddr;
  end

  // R2
  call_ret_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fetch && strobe.nextSrc == NXT_TGT) |=> (pcInc == $past(target) + ADDR_W'(1)));

endmodule

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
  import stack_seq_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int SEL_W   = 4,
  parameter int LOW_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instr,
  input  logic               flag,
  input  logic               irqReq,
  input  logic               dmaReq,
  input  logic               statusWr,
  input  logic               statusIe,
  input  logic               statusCe,
  output seqStrobe_t         strobe,
  output addrSel_e           addrSel,
  output logic               memRead,
  output logic               memWrite,
  output logic               busOe,
  output logic               dmaAck,
  output logic               irqAck,
  output logic [SEL_W-1:0]   r1Sel,
  output logic [SEL_W-1:0]   r2Sel,
  output logic               r2Write,
  output logic               psPush,
  output logic               psPop,
  output logic               rsPush,
  output logic               rsPop,
  output logic               pushRet,
  output logic [LOW_W-1:0]   aluField,
  output immMode_e           immMode,
  output logic               intEn,
  output logic               cacheEn
);

  localparam int OP_W    = 3;
  localparam int NXT_BIT = INSTR_W - OP_W - 1;
  localparam int R1_HI   = NXT_BIT - 1;
  localparam int R2_HI   = R1_HI - SEL_W;
  localparam int PS_LO   = LOW_W + 2;
  localparam int RS_LO   = LOW_W;

  opcode_e          op;
  logic             nextBit;
  logic [1:0]       psCode;
  logic [1:0]       rsCode;
  seqState_e        state, nextState, resumeState;
  logic             ieReg, ceReg;
  logic             memIsLoad;
  logic [SEL_W-1:0] memR2;

  assign op       = opcode_e'(instr[INSTR_W-1 -: OP_W]);
  assign nextBit  = instr[NXT_BIT];
  assign psCode   = instr[PS_LO +: 2];
  assign rsCode   = instr[RS_LO +: 2];
  assign aluField = instr[LOW_W-1:0];
  assign r1Sel    = instr[R1_HI -: SEL_W];
  assign intEn    = ieReg;
  assign cacheEn  = ceReg;

  always_comb begin
    nextState = state;
    strobe    = '{nextSrc: NXT_INC, fetch: 1'b0, retCur: 1'b0};
    addrSel   = ADDR_NONE;
    memRead   = 1'b0;
    memWrite  = 1'b0;
    busOe     = 1'b1;
    dmaAck    = 1'b0;
    irqAck    = 1'b0;
    r2Sel     = instr[R2_HI -: SEL_W];
    r2Write   = 1'b0;
    psPush    = 1'b0;
    psPop     = 1'b0;
    rsPush    = 1'b0;
    rsPop     = 1'b0;
    pushRet   = 1'b0;
    immMode   = IMM_ALU;
    unique case (state)
      ST_BOOT: begin
        if (dmaReq) nextState = ST_DMA;
        else begin
          strobe.nextSrc = NXT_RESET;
          strobe.fetch   = 1'b1;
          addrSel        = ADDR_FETCH;
          memRead        = 1'b1;
          nextState      = ST_EXEC;
        end
      end
      ST_EXEC: begin
        if (dmaReq) nextState = ST_DMA;
        else if (irqReq && ieReg) begin
          // behaves as a call to the vector in place of the current word
          irqAck         = 1'b1;
          strobe.nextSrc = NXT_IRQ;
          strobe.fetch   = 1'b1;
          strobe.retCur  = 1'b1;
          addrSel        = ADDR_FETCH;
          memRead        = 1'b1;
          rsPush         = 1'b1;
          pushRet        = 1'b1;
        end else begin
          strobe.fetch = 1'b1;
          addrSel      = ADDR_FETCH;
          memRead      = 1'b1;
          unique case (op)
            OP_CALL: begin
              strobe.nextSrc = NXT_TGT;
              rsPush         = 1'b1;
              pushRet        = 1'b1;
            end
            OP_BR:  strobe.nextSrc = NXT_TGT;
            OP_CBR: strobe.nextSrc = flag ? NXT_INC : NXT_TGT;
            default: begin
              strobe.nextSrc = nextBit ? NXT_RET : NXT_INC;
              psPush = (psCode == STK_PUSH);
              psPop  = (psCode == STK_POP);
              rsPush = (rsCode == STK_PUSH);
              rsPop  = (rsCode == STK_POP);
              unique case (op)
                OP_MICRO: r2Write = 1'b1;
                OP_LAL: begin
                  immMode = IMM_LO;
                  r2Write = 1'b1;
                end
                OP_LAH: begin
                  immMode = IMM_HI;
                  r2Write = 1'b1;
                end
                default: begin
                  immMode   = IMM_LO;
                  nextState = ST_DATA;
                end
              endcase
            end
          endcase
        end
      end
      ST_DATA: begin
        addrSel   = ADDR_DATA;
        memRead   = memIsLoad;
        memWrite  = !memIsLoad;
        r2Write   = memIsLoad;
        r2Sel     = memR2;
        nextState = ST_EXEC;
      end
      default: begin
        dmaAck = 1'b1;
        busOe  = 1'b0;
        if (!dmaReq) nextState = resumeState;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_BOOT;
      resumeState <= ST_BOOT;
      ieReg       <= 1'b0;
      ceReg       <= 1'b0;
      memIsLoad   <= 1'b0;
      memR2       <= '0;
    end else begin
      state <= nextState;
      if (state != ST_DMA && nextState == ST_DMA) resumeState <= state;
      if (irqAck)        ieReg <= 1'b0;
      else if (statusWr) ieReg <= statusIe;
      if (statusWr) ceReg <= statusCe;
      if (nextState == ST_DATA) begin
        memIsLoad <= (op == OP_LOAD);
        memR2     <= instr[R2_HI -: SEL_W];
      end
    end
  end

  // R8
  ps_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(psPush && psPop));
  // R8
  rs_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(rsPush && rsPop));
  // R7
  data_after_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrSel == ADDR_DATA) |-> ($past(immMode) == IMM_LO && $past(addrSel) == ADDR_FETCH));
  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN) irqAck |=> !intEn);
  // R10
  irq_not_in_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrSel == ADDR_DATA || !intEn) |-> !irqAck);
  // R11
  dma_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaAck |-> (!busOe && !memRead && !memWrite && addrSel == ADDR_NONE));
  // R12
  dma_over_irq_chk: assert property (@(posedge clk) disable iff (!rstN) dmaReq |-> !irqAck);

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int INSTR_W   = 32,
  parameter int SEL_W     = 4,
  parameter int LOW_W     = 16,
  parameter int RESET_VEC = 0,
  parameter int IRQ_VEC   = 1,
  localparam int ADDR_W   = INSTR_W - 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instr,
  input  logic               flag,
  input  logic [ADDR_W-1:0]  rsTop,
  input  logic               irqReq,
  input  logic               dmaReq,
  input  logic               statusWr,
  input  logic               statusIe,
  input  logic               statusCe,
  output logic [ADDR_W-1:0]  fetchAddr,
  output logic [1:0]         addrSel,
  output logic               memRead,
  output logic               memWrite,
  output logic               busOe,
  output logic               dmaAck,
  output logic               irqAck,
  output logic [SEL_W-1:0]   r1Sel,
  output logic [SEL_W-1:0]   r2Sel,
  output logic               r2Write,
  output logic               psPush,
  output logic               psPop,
  output logic               rsPush,
  output logic               rsPop,
  output logic               pushRet,
  output logic [ADDR_W-1:0]  retAddr,
  output logic [LOW_W-1:0]   aluField,
  output logic [1:0]         immMode,
  output logic               intEn,
  output logic               cacheEn
);

  seqStrobe_t strobe;
  addrSel_e   addrSelE;
  immMode_e   immModeE;

  assign addrSel = addrSelE;
  assign immMode = immModeE;

  stack_seq_ctrl #(.INSTR_W(INSTR_W), .SEL_W(SEL_W), .LOW_W(LOW_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .instr(instr), .flag(flag),
    .irqReq(irqReq), .dmaReq(dmaReq),
    .statusWr(statusWr), .statusIe(statusIe), .statusCe(statusCe),
    .strobe(strobe), .addrSel(addrSelE), .memRead(memRead), .memWrite(memWrite),
    .busOe(busOe), .dmaAck(dmaAck), .irqAck(irqAck),
    .r1Sel(r1Sel), .r2Sel(r2Sel), .r2Write(r2Write),
    .psPush(psPush), .psPop(psPop), .rsPush(rsPush), .rsPop(rsPop),
    .pushRet(pushRet), .aluField(aluField), .immMode(immModeE),
    .intEn(intEn), .cacheEn(cacheEn)
  );

  stack_seq_dpath #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC), .IRQ_VEC(IRQ_VEC)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .target(instr[ADDR_W-1:0]), .rsTop(rsTop),
    .fetchAddr(fetchAddr), .retAddr(retAddr)
  );

  // R1
  boot_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rstN) && !dmaReq) |-> (fetchAddr == ADDR_W'(RESET_VEC) && memRead && !intEn));
  // R9
  irq_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |-> (fetchAddr == ADDR_W'(IRQ_VEC) && pushRet && !r2Write));

endmodule

// File: tb/stack_seq_tb.sv
module stack_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instr = '0;
  logic        flag = 1'b0;
  logic [28:0] rsTop = '0;
  logic        irqReq = 1'b0, dmaReq = 1'b0;
  logic        statusWr = 1'b0, statusIe = 1'b0, statusCe = 1'b0;

  logic [28:0] fetchAddr, retAddr;
  logic [1:0]  addrSel, immMode;
  logic        memRead, memWrite, busOe, dmaAck, irqAck, r2Write;
  logic        psPush, psPop, rsPush, rsPop, pushRet, intEn, cacheEn;
  logic [3:0]  r1Sel, r2Sel;
  logic [15:0] aluField;

  int nRun = 0;
  int nFail = 0;
  logic [28:0] expPc = '0;
  logic expIe = 1'b0, expCe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_seq u_dut (
    .clk(clk), .rstN(rstN), .instr(instr), .flag(flag), .rsTop(rsTop),
    .irqReq(irqReq), .dmaReq(dmaReq),
    .statusWr(statusWr), .statusIe(statusIe), .statusCe(statusCe),
    .fetchAddr(fetchAddr), .addrSel(addrSel), .memRead(memRead), .memWrite(memWrite),
    .busOe(busOe), .dmaAck(dmaAck), .irqAck(irqAck),
    .r1Sel(r1Sel), .r2Sel(r2Sel), .r2Write(r2Write),
    .psPush(psPush), .psPop(psPop), .rsPush(rsPush), .rsPop(rsPop),
    .pushRet(pushRet), .retAddr(retAddr), .aluField(aluField), .immMode(immMode),
    .intEn(intEn), .cacheEn(cacheEn)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkOp(input int op, input bit nb, input int r1, input int r2,
                                       input int ps, input int rs, input int low);
    return {op[2:0], nb, r1[3:0], r2[3:0], ps[1:0], rs[1:0], low[15:0]};
  endfunction

  function automatic logic [31:0] mkFlow(input int op, input logic [28:0] tgt);
    return {op[2:0], tgt};
  endfunction

  function automatic logic [28:0] expNext(input logic [31:0] w, input logic f, input logic [28:0] rt,
                                          input logic [28:0] pc);
    case (w[31:29])
      3'd0, 3'd1: return w[28:0];
      3'd2:       return f ? pc + 29'd1 : w[28:0];
      default:    return w[28] ? rt : pc + 29'd1;
    endcase
  endfunction

  function automatic logic [3:0] expStk(input logic [31:0] w);
    if (w[31:29] < 3'd3) return {2'b00, w[31:29] == 3'd0, 1'b0};
    return {w[19:18] == 2'b01, w[19:18] == 2'b10, w[17:16] == 2'b01, w[17:16] == 2'b10};
  endfunction

  // one instruction in execute, plus its data cycle for load/store
  task automatic runOne(input logic [31:0] w, input logic f, input logic [28:0] rt,
                        input bit irqInData, input bit dmaInData);
    logic [2:0]  op;
    logic [28:0] nxt;
    string       tagN;
    op  = w[31:29];
    nxt = expNext(w, f, rt, expPc);
    tagN = (op == 3'd0) ? "R2" : (op < 3'd3) ? "R3" : "R5";
    @(negedge clk);
    instr = w; flag = f; rsTop = rt;
    #1;
    chk(tagN, "fetchAddr", {3'b0, fetchAddr}, {3'b0, nxt});
    chk(tagN, "fetch strobe", {addrSel, memRead}, {2'd1, 1'b1});
    chk("R4", "stack bits", {psPush, psPop, rsPush, rsPop}, expStk(w));
    chk("R2", "pushRet", pushRet, op == 3'd0);
    if (op == 3'd0) chk("R2", "retAddr", retAddr, expPc + 29'd1);
    if (op >= 3'd3) begin
      chk("R4", "r1Sel", r1Sel, w[27:24]);
      chk("R4", "aluField", aluField, w[15:0]);
    end
    chk("R6", "r2Write", r2Write, (op == 3'd3 || op == 3'd6 || op == 3'd7));
    chk("R6", "immMode", immMode, (op == 3'd7) ? 2'd2 : (op >= 3'd4) ? 2'd1 : 2'd0);
    chk("R10", "irqAck idle", irqAck, 1'b0);
    chk("R11", "busOe", {busOe, dmaAck}, 2'b10);
    chk("R13", "status bits", {intEn, cacheEn}, {expIe, expCe});
    expPc = nxt;
    @(posedge clk); #1;
    if (op == 3'd4 || op == 3'd5) begin
      @(negedge clk);
      instr = $urandom; irqReq = irqInData; dmaReq = dmaInData;
      #1;
      chk("R7", "addrSel data", addrSel, 2'd2);
      chk("R7", "rd/wr", {memRead, memWrite}, (op == 3'd4) ? 2'b10 : 2'b01);
      chk("R7", "r2Write", r2Write, op == 3'd4);
      chk("R7", "r2Sel held", r2Sel, w[23:20]);
      chk("R7", "no stack", {psPush, psPop, rsPush, rsPop}, 4'b0);
      chk("R10", "irq blocked in data", irqAck, 1'b0);
      chk("R11", "dma waits", dmaAck, 1'b0);
      @(posedge clk); #1;
    end
  endtask

  task automatic takeIrq(input logic [31:0] w);
    @(negedge clk);
    instr = w; irqReq = 1'b1;
    #1;
    chk("R9", "irqAck", irqAck, 1'b1);
    chk("R9", "vector", fetchAddr, 29'd1);
    chk("R9", "ret push", {rsPush, pushRet}, 2'b11);
    chk("R9", "retAddr", retAddr, expPc);
    chk("R9", "discarded", {r2Write, psPush, psPop, rsPop}, 4'b0);
    @(posedge clk); #1;
    irqReq = 1'b0;
    chk("R9", "intEn cleared", intEn, 1'b0);
    expPc = 29'd1; expIe = 1'b0;
  endtask

  task automatic setStatus(input logic ie, input logic ce);
    statusWr = 1'b1; statusIe = ie; statusCe = ce;
    runOne(mkOp(3, 0, 0, 0, 0, 0, 0), 1'b0, '0, 0, 0);
    statusWr = 1'b0;
    expIe = ie; expCe = ce;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 50000);
    nFail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin : main
    logic [31:0] w;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 boot fetch
    chk("R1", "fetchAddr", fetchAddr, 29'd0);
    chk("R1", "fetch", {addrSel, memRead}, {2'd1, 1'b1});
    chk("R1", "status", {intEn, cacheEn}, 2'b00);
    chk("R1", "bus", {busOe, dmaAck}, 2'b10);
    @(posedge clk); #1;
    expPc = '0;

    // directed decode cases
    runOne(mkFlow(0, 29'h0ABCDE), 1'b0, '0, 0, 0);
    runOne(mkFlow(1, 29'h100), 1'b1, '0, 0, 0);
    runOne(mkFlow(2, 29'h200), 1'b0, '0, 0, 0);
    runOne(mkFlow(2, 29'h300), 1'b1, '0, 0, 0);
    runOne(mkOp(3, 1, 2, 3, 0, 2, 16'hBEEF), 1'b0, 29'h1555, 0, 0);
    runOne(mkOp(3, 0, 1, 0, 1, 2, 16'h1234), 1'b0, '0, 0, 0);
    runOne(mkOp(3, 0, 4, 5, 3, 3, 16'h0001), 1'b0, '0, 0, 0);
    runOne(mkOp(6, 0, 0, 0, 1, 0, 16'h04D2), 1'b0, '0, 0, 0);
    runOne(mkOp(7, 1, 0, 0, 1, 0, 16'hFEDC), 1'b0, 29'h0777, 0, 0);
    runOne(mkOp(4, 0, 1, 6, 1, 0, 16'h0147), 1'b0, '0, 0, 0);
    runOne(mkOp(5, 1, 0, 9, 2, 0, 16'h0000), 1'b0, 29'h0042, 0, 0);

    // R10 request while disabled is ignored
    irqReq = 1'b1;
    runOne(mkOp(3, 0, 1, 1, 0, 0, 0), 1'b0, '0, 0, 0);
    irqReq = 1'b0;

    // R13 enable both status bits
    setStatus(1'b1, 1'b1);

    // R10 interrupt raised inside the data cycle of a load, taken after
    runOne(mkOp(4, 0, 2, 7, 0, 0, 16'h0010), 1'b0, '0, 1, 0);
    takeIrq(mkOp(3, 0, 1, 2, 1, 0, 0));

    // R12 DMA and interrupt in the same cycle
    setStatus(1'b1, 1'b1);
    w = mkOp(3, 0, 3, 3, 1, 1, 16'h00AA);
    @(negedge clk);
    instr = w; dmaReq = 1'b1; irqReq = 1'b1;
    #1;
    chk("R12", "irq held off", irqAck, 1'b0);
    chk("R11", "stall cycle", {addrSel, memRead, r2Write, psPush}, 5'b0);
    chk("R11", "ack not yet", dmaAck, 1'b0);
    @(posedge clk); #1;
    @(negedge clk); #1;
    chk("R11", "granted", {dmaAck, busOe}, 2'b10);
    @(posedge clk); #1;
    @(negedge clk); #1;
    dmaReq = 1'b0;
    #1;
    chk("R11", "ack through release", {dmaAck, busOe}, 2'b10);
    chk("R12", "irq waits for bus", irqAck, 1'b0);
    @(posedge clk); #1;
    takeIrq(w);

    // R11 DMA raised in the data cycle of a store
    runOne(mkOp(5, 0, 1, 4, 2, 0, 16'h0008), 1'b0, '0, 0, 1);
    @(negedge clk); #1;
    chk("R11", "stall after store", {dmaAck, addrSel, memWrite}, 4'b0);
    @(posedge clk); #1;
    @(negedge clk); #1;
    chk("R11", "granted after store", {dmaAck, busOe}, 2'b10);
    dmaReq = 1'b0;
    @(posedge clk); #1;

    // constrained random instruction stream
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rw;
      rw = $urandom;
      runOne(rw, 1'($urandom), 29'($urandom), 0, 0);
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule